// File: doc/BRIEF.md
# Event Window Statistics Recorder

The recorder watches a bus controller's fault indications and a thermal monitor. When one of several trigger conditions appears, it opens an event window. While the window stays open it accumulates statistics on the sampled temperature proxy, the supply rail, the transmit and receive error counters and the bus fault activity. When the window closes it writes one fixed-format summary record into a small ring of the most recent events, which a readout port can index without disturbing capture.

A record describes the window's time span, its temperature peak and average, the lowest rail sample, the error-counter peaks and net rises, how many bus-off entries and error frames occurred, and how long the recovery ran. It also carries a version tag for the window definition and a label that says which temperature reference the proxy stands for. Only one window is open at a time. It ends when recovery completes or when a length limit runs out, whichever comes first. Once the ring is full, each new record replaces the oldest one and a loss counter advances.

Top module: `evt_window_recorder`

## Requirements
- R1: A window opens, with `winActive` high from the next cycle, on any one of four triggers seen while no window is open: a rising edge of `busOff`, a `thermTrip` pulse, a `recovStart` pulse, or `errPassive` held high for `EP_HOLD` consecutive cycles (it opens on the `EP_HOLD`-th cycle; a shorter hold opens nothing). Triggers seen while a window is open, including on its closing cycle, open nothing.
- R2: An open window closes on a `recovEnd` pulse, or on its `MAX_WIN`-th cycle counting the trigger cycle as the first. The record is written on that closing edge and `winActive` is low from the next cycle.
- R3: `rdStartTs` is `tsNow` on the trigger cycle and `rdEndTs` is `tsNow` on the closing cycle.
- R4: `rdTempMax` and `rdTempMean` are the maximum and the truncated integer mean (sum divided by count) of the `tempVal` samples with `tempValid` high, from the trigger cycle through the closing cycle. With no samples both are 0.
- R5: `rdRailMin` is the minimum `railVal` over the window cycles that have `railValid` high. With no samples it is all ones (4095 at default width).
- R6: `rdTecPeak`/`rdRecPeak` are the largest `txErrCnt`/`rxErrCnt` seen in the window. `rdTecDelta`/`rdRecDelta` are the value on the closing cycle minus the value on the trigger cycle, or 0 if the counter fell.
- R7: `rdBusOffCnt` counts the rising edges of `busOff` in the window, including one that opened it. `rdErrFrameCnt` counts the window cycles that have `errFrame` high.
- R8: `rdRecovDur` is the closing-cycle `tsNow` minus `tsNow` at the first `recovStart` pulse in the window (the trigger cycle included). It is 0 if no recovery started.
- R9: `rdVersion` equals the `WIN_VER` parameter. `rdTempRef` is the `tempRef` label on the trigger cycle (0 ambient, 1 case, 2 junction proxy).
- R10: The ring holds `DEPTH` records. `rdIdx` 0 selects the newest record and larger indices select older ones. `rdValid` is high when `rdIdx` is less than `recCount`, and `recCount` stops at `DEPTH`.
- R11: A record written while the ring is full replaces the oldest record and increments `overflowCnt`. No other write changes `overflowCnt`.
- R12: While `rstN` is low and after it is released, no window is open and `recCount`, `overflowCnt` and `rdValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tsNow | input | TS_W | Free-running timestamp |
| tempVal | input | TEMP_W | Temperature proxy sample |
| tempValid | input | 1 | Temperature sample valid |
| tempRef | input | 2 | Temperature reference label |
| railVal | input | RAIL_W | Rail voltage sample |
| railValid | input | 1 | Rail sample valid |
| txErrCnt | input | CNT_W | Transmit error counter |
| rxErrCnt | input | CNT_W | Receive error counter |
| busOff | input | 1 | Bus-off state level |
| errPassive | input | 1 | Error-passive state level |
| thermTrip | input | 1 | Thermal trip pulse |
| recovStart | input | 1 | Recovery start pulse |
| recovEnd | input | 1 | Recovery end pulse |
| errFrame | input | 1 | Error frame pulse |
| rdIdx | input | log2(DEPTH) | Readout index, 0 = newest |
| winActive | output | 1 | A window is open |
| recCount | output | log2(DEPTH+1) | Records held |
| overflowCnt | output | OVF_W | Records lost to overwrite |
| rdValid | output | 1 | Indexed record exists |
| rdVersion | output | VER_W | Window-definition version |
| rdTempRef | output | 2 | Temperature reference label |
| rdStartTs | output | TS_W | Window start timestamp |
| rdEndTs | output | TS_W | Window end timestamp |
| rdTempMax | output | TEMP_W | Maximum temperature |
| rdTempMean | output | TEMP_W | Mean temperature |
| rdRailMin | output | RAIL_W | Minimum rail value |
| rdTecPeak | output | CNT_W | Transmit counter peak |
| rdRecPeak | output | CNT_W | Receive counter peak |
| rdTecDelta | output | CNT_W | Transmit counter rise |
| rdRecDelta | output | CNT_W | Receive counter rise |
| rdBusOffCnt | output | EVC_W | Bus-off entries |
| rdErrFrameCnt | output | EVC_W | Error frames |
| rdRecovDur | output | TS_W | Recovery duration |

## Verification
Each trigger source opens its own window while random temperature, rail, error-frame and drifting counter traffic runs in the background. Because every window starts from a different source, a source that opens nothing, or that is counted on the wrong cycle, shows up in the start timestamp and in the bus-off count. One window is ended by the length limit, with a second bus-off edge and a late recovery start inside it, and the others are ended by recovery. This separates the two close paths and tests the recovery-duration origin. An error-passive hold one cycle short of the limit, a trigger that arrives on a closing cycle, and a trigger during an open window test the cases where a trigger must open nothing. A window with no samples, eight windows pushed into a four-entry ring, and a readout index sweep test the empty defaults, the overwrite order and the loss count.

// File: rtl/evt_rec_pkg.sv
package evt_rec_pkg;

  // Strobes from the window controller to the statistics datapath
  typedef struct packed {
    logic openWin;    // trigger accepted this cycle, window starts
    logic inWin;      // window already open this cycle
    logic closeWin;   // last cycle of the open window
    logic busOffEdge; // bus-off rising edge this cycle
  } winStrobes_t;

  // Label for what the temperature proxy refers to
  typedef enum logic [1:0] {
    TREF_AMBIENT  = 2'd0,
    TREF_CASE     = 2'd1,
    TREF_JUNCTION = 2'd2,
    TREF_RSVD     = 2'd3
  } tempRef_e;

endpackage

// File: rtl/evt_rec_ctrl.sv
module evt_rec_ctrl
  import evt_rec_pkg::*;
#(
  parameter int EP_HOLD = 16,
  parameter int MAX_WIN = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busOff,
  input  logic        errPassive,
  input  logic        thermTrip,
  input  logic        recovStart,
  input  logic        recovEnd,
  output winStrobes_t strobes,
  output logic        winActive
);

  localparam int LEN_W = $clog2(MAX_WIN + 1);
  localparam int EP_W  = $clog2(EP_HOLD + 1);

  typedef enum logic {ST_IDLE, ST_OPEN} winState_e;

  winState_e        state, stateNext;
  logic             busOffQ;
  logic [EP_W-1:0]  epRun;
  logic [LEN_W-1:0] lenCnt;
  logic             busOffEdge, epFire, anyTrig, lenLimit;

  assign busOffEdge = busOff & ~busOffQ;
  assign epFire     = errPassive && (epRun == EP_W'(EP_HOLD - 1));
  assign anyTrig    = busOffEdge | epFire | thermTrip | recovStart;
  assign lenLimit   = (lenCnt == LEN_W'(MAX_WIN - 1));

  always_comb begin
    stateNext          = state;
    strobes            = '0;
    strobes.busOffEdge = busOffEdge;
    unique case (state)
      ST_IDLE: begin
        if (anyTrig) begin
          strobes.openWin = 1'b1;
          stateNext       = ST_OPEN;
        end
      end
      ST_OPEN: begin
        strobes.inWin = 1'b1;
        if (recovEnd || lenLimit) begin
          strobes.closeWin = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      busOffQ <= 1'b0;
      epRun   <= '0;
      lenCnt  <= '0;
    end else begin
      state   <= stateNext;
      busOffQ <= busOff;
      if (!errPassive)                  epRun <= '0;
      else if (epRun != EP_W'(EP_HOLD)) epRun <= epRun + EP_W'(1);
      if (strobes.openWin)       lenCnt <= LEN_W'(1);
      else if (strobes.closeWin) lenCnt <= '0;
      else if (strobes.inWin)    lenCnt <= lenCnt + LEN_W'(1);
    end
  end

  assign winActive = (state == ST_OPEN);

endmodule

// File: rtl/evt_rec_datapath.sv
module evt_rec_datapath
  import evt_rec_pkg::*;
#(
  parameter int TS_W    = 32,
  parameter int TEMP_W  = 12,
  parameter int RAIL_W  = 12,
  parameter int CNT_W   = 8,
  parameter int EVC_W   = 8,
  parameter int VER_W   = 8,
  parameter int WIN_VER = 1,
  parameter int MAX_WIN = 64,
  localparam int REC_W  = VER_W + 2 + 3*TS_W + 2*TEMP_W + RAIL_W + 4*CNT_W + 2*EVC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobes_t       strobes,
  input  logic [TS_W-1:0]   tsNow,
  input  logic [TEMP_W-1:0] tempVal,
  input  logic              tempValid,
  input  logic [1:0]        tempRef,
  input  logic [RAIL_W-1:0] railVal,
  input  logic              railValid,
  input  logic [CNT_W-1:0]  txErrCnt,
  input  logic [CNT_W-1:0]  rxErrCnt,
  input  logic              recovStart,
  input  logic              errFrame,
  output logic [REC_W-1:0]  recData
);

  localparam int SAMP_W = $clog2(MAX_WIN + 1);
  localparam int SUM_W  = TEMP_W + SAMP_W;

  typedef struct packed {
    logic [TS_W-1:0]   startTs;
    tempRef_e          tRef;
    logic [TEMP_W-1:0] tMax;
    logic [SUM_W-1:0]  tSum;
    logic [SAMP_W-1:0] tCnt;
    logic [RAIL_W-1:0] rMin;
    logic [CNT_W-1:0]  tecOpen;
    logic [CNT_W-1:0]  recOpen;
    logic [CNT_W-1:0]  tecPk;
    logic [CNT_W-1:0]  recPk;
    logic [EVC_W-1:0]  boN;
    logic [EVC_W-1:0]  efN;
    logic              recSt;
    logic [TS_W-1:0]   recTs;
  } acc_t;

  acc_t accQ, accB, accN;

  // Base: fresh window state on open, else the running accumulation
  always_comb begin
    if (strobes.openWin) begin
      accB         = '0;
      accB.startTs = tsNow;
      accB.tRef    = tempRef_e'(tempRef);
      accB.rMin    = '1;
      accB.tecOpen = txErrCnt;
      accB.recOpen = rxErrCnt;
    end else begin
      accB = accQ;
    end
  end

  // Merge this cycle's inputs into the base
  always_comb begin
    accN = accB;
    if (tempValid) begin
      if (tempVal > accB.tMax) accN.tMax = tempVal;
      accN.tSum = accB.tSum + SUM_W'(tempVal);
      accN.tCnt = accB.tCnt + SAMP_W'(1);
    end
    if (railValid && (railVal < accB.rMin)) accN.rMin = railVal;
    if (txErrCnt > accB.tecPk) accN.tecPk = txErrCnt;
    if (rxErrCnt > accB.recPk) accN.recPk = rxErrCnt;
    if (strobes.busOffEdge && (accB.boN != '1)) accN.boN = accB.boN + EVC_W'(1);
    if (errFrame && (accB.efN != '1)) accN.efN = accB.efN + EVC_W'(1);
    if (recovStart && !accB.recSt) begin
      accN.recSt = 1'b1;
      accN.recTs = tsNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (strobes.openWin || (strobes.inWin && !strobes.closeWin)) begin
      accQ <= accN;
    end
  end

  // Closing-cycle record fields
  logic [TEMP_W-1:0] meanVal;
  logic [CNT_W-1:0]  tecDl, recDl;
  logic [TS_W-1:0]   durVal;

  always_comb begin
    meanVal = (accN.tCnt == '0) ? '0 : TEMP_W'(accN.tSum / SUM_W'(accN.tCnt));
    tecDl   = (txErrCnt >= accN.tecOpen) ? (txErrCnt - accN.tecOpen) : '0;
    recDl   = (rxErrCnt >= accN.recOpen) ? (rxErrCnt - accN.recOpen) : '0;
    durVal  = accN.recSt ? (tsNow - accN.recTs) : '0;
  end

  assign recData = {VER_W'(WIN_VER), accN.tRef, accN.startTs, tsNow,
                    accN.tMax, meanVal, accN.rMin,
                    accN.tecPk, accN.recPk, tecDl, recDl,
                    accN.boN, accN.efN, durVal};

endmodule

// File: rtl/evt_rec_ring.sv
module evt_rec_ring #(
  parameter int DATA_W  = 64,
  parameter int DEPTH   = 4,
  parameter int OVF_W   = 8,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PTR_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [FILL_W-1:0] fillCnt,
  output logic [OVF_W-1:0]  ovfCnt
);

  if ((1 << PTR_W) != DEPTH || DEPTH < 2) begin : g_depthCheck
    $error("ring depth must be a power of two of at least 2");
  end

  logic [PTR_W-1:0]  wrPtr;
  logic [DATA_W-1:0] slot [DEPTH];
  logic              isFull;

  assign isFull = (fillCnt == FILL_W'(DEPTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      fillCnt <= '0;
      ovfCnt  <= '0;
    end else if (wrEn) begin
      wrPtr <= wrPtr + PTR_W'(1);
      if (!isFull)            fillCnt <= fillCnt + FILL_W'(1);
      else if (ovfCnt != '1)  ovfCnt  <= ovfCnt + OVF_W'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               slot[g] <= '0;
      else if (wrEn && (wrPtr == PTR_W'(g)))   slot[g] <= wrData;
    end
  end

  // Newest-first addressing: index 0 is the slot written last
  logic [PTR_W-1:0] rdSel;
  assign rdSel   = wrPtr - PTR_W'(1) - rdIdx;
  assign rdData  = slot[rdSel];
  assign rdValid = (FILL_W'(rdIdx) < fillCnt);

endmodule

// File: rtl/evt_window_recorder.sv
module evt_window_recorder
  import evt_rec_pkg::*;
#(
  parameter int TS_W    = 32,
  parameter int TEMP_W  = 12,
  parameter int RAIL_W  = 12,
  parameter int CNT_W   = 8,
  parameter int EVC_W   = 8,
  parameter int VER_W   = 8,
  parameter int WIN_VER = 8'h3A,
  parameter int DEPTH   = 4,
  parameter int OVF_W   = 8,
  parameter int MAX_WIN = 64,
  parameter int EP_HOLD = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [TS_W-1:0]              tsNow,
  input  logic [TEMP_W-1:0]            tempVal,
  input  logic                         tempValid,
  input  logic [1:0]                   tempRef,
  input  logic [RAIL_W-1:0]            railVal,
  input  logic                         railValid,
  input  logic [CNT_W-1:0]             txErrCnt,
  input  logic [CNT_W-1:0]             rxErrCnt,
  input  logic                         busOff,
  input  logic                         errPassive,
  input  logic                         thermTrip,
  input  logic                         recovStart,
  input  logic                         recovEnd,
  input  logic                         errFrame,
  input  logic [$clog2(DEPTH)-1:0]     rdIdx,
  output logic                         winActive,
  output logic [$clog2(DEPTH+1)-1:0]   recCount,
  output logic [OVF_W-1:0]             overflowCnt,
  output logic                         rdValid,
  output logic [VER_W-1:0]             rdVersion,
  output logic [1:0]                   rdTempRef,
  output logic [TS_W-1:0]              rdStartTs,
  output logic [TS_W-1:0]              rdEndTs,
  output logic [TEMP_W-1:0]            rdTempMax,
  output logic [TEMP_W-1:0]            rdTempMean,
  output logic [RAIL_W-1:0]            rdRailMin,
  output logic [CNT_W-1:0]             rdTecPeak,
  output logic [CNT_W-1:0]             rdRecPeak,
  output logic [CNT_W-1:0]             rdTecDelta,
  output logic [CNT_W-1:0]             rdRecDelta,
  output logic [EVC_W-1:0]             rdBusOffCnt,
  output logic [EVC_W-1:0]             rdErrFrameCnt,
  output logic [TS_W-1:0]              rdRecovDur
);

  localparam int REC_W = VER_W + 2 + 3*TS_W + 2*TEMP_W + RAIL_W + 4*CNT_W + 2*EVC_W;

  winStrobes_t       strobes;
  logic [REC_W-1:0]  recData, rdData;

  evt_rec_ctrl #(.EP_HOLD(EP_HOLD), .MAX_WIN(MAX_WIN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busOff     (busOff),
    .errPassive (errPassive),
    .thermTrip  (thermTrip),
    .recovStart (recovStart),
    .recovEnd   (recovEnd),
    .strobes    (strobes),
    .winActive  (winActive)
  );

  evt_rec_datapath #(
    .TS_W(TS_W), .TEMP_W(TEMP_W), .RAIL_W(RAIL_W), .CNT_W(CNT_W),
    .EVC_W(EVC_W), .VER_W(VER_W), .WIN_VER(WIN_VER), .MAX_WIN(MAX_WIN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .tsNow      (tsNow),
    .tempVal    (tempVal),
    .tempValid  (tempValid),
    .tempRef    (tempRef),
    .railVal    (railVal),
    .railValid  (railValid),
    .txErrCnt   (txErrCnt),
    .rxErrCnt   (rxErrCnt),
    .recovStart (recovStart),
    .errFrame   (errFrame),
    .recData    (recData)
  );

  evt_rec_ring #(.DATA_W(REC_W), .DEPTH(DEPTH), .OVF_W(OVF_W)) u_ring (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (strobes.closeWin),
    .wrData  (recData),
    .rdIdx   (rdIdx),
    .rdData  (rdData),
    .rdValid (rdValid),
    .fillCnt (recCount),
    .ovfCnt  (overflowCnt)
  );

  assign {rdVersion, rdTempRef, rdStartTs, rdEndTs, rdTempMax, rdTempMean,
          rdRailMin, rdTecPeak, rdRecPeak, rdTecDelta, rdRecDelta,
          rdBusOffCnt, rdErrFrameCnt, rdRecovDur} = rdData;

endmodule

// File: rtl/evt_rec_chk.sv
module evt_rec_chk #(
  parameter int DEPTH   = 4,
  parameter int OVF_W   = 8,
  parameter int MAX_WIN = 64
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       thermTrip,
  input logic                       recovStart,
  input logic                       recovEnd,
  input logic                       winActive,
  input logic [$clog2(DEPTH+1)-1:0] recCount,
  input logic [OVF_W-1:0]           overflowCnt
);

  localparam int RUN_W = $clog2(MAX_WIN + 1);
  localparam int FILL_W = $clog2(DEPTH + 1);

  // consecutive open cycles seen before the current one
  logic [RUN_W-1:0] actRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           actRun <= '0;
    else if (!winActive)                 actRun <= '0;
    else if (actRun != RUN_W'(MAX_WIN))  actRun <= actRun + RUN_W'(1);
  end

  // R1
  trig_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!winActive && (thermTrip || recovStart)) |=> winActive);

  // R2
  recov_end_closes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winActive && recovEnd) |=> !winActive);

  // R2
  win_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    winActive |-> (actRun < RUN_W'(MAX_WIN - 1)));

  // R10
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    recCount <= FILL_W'(DEPTH));

  // R10
  fill_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(winActive) && ($past(recCount) < FILL_W'(DEPTH)))
      |-> (recCount == $past(recCount) + FILL_W'(1)));

  // R11
  ovf_only_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflowCnt != $past(overflowCnt)) |-> ($past(recCount) == FILL_W'(DEPTH)));

endmodule

bind evt_window_recorder evt_rec_chk #(.DEPTH(DEPTH), .OVF_W(OVF_W), .MAX_WIN(MAX_WIN)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .thermTrip   (thermTrip),
  .recovStart  (recovStart),
  .recovEnd    (recovEnd),
  .winActive   (winActive),
  .recCount    (recCount),
  .overflowCnt (overflowCnt)
);

// File: tb/evt_window_recorder_tb.sv
module evt_window_recorder_tb;
  import evt_rec_pkg::*;

  localparam int TS_W = 32, TEMP_W = 12, RAIL_W = 12, CNT_W = 8, EVC_W = 8;
  localparam int VER_W = 8, WIN_VER = 8'h3A, DEPTH = 4, OVF_W = 8;
  localparam int MAX_WIN = 64, EP_HOLD = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN = 1'b0;
  logic [TS_W-1:0]   tsNow = 100;
  logic [TEMP_W-1:0] tempVal = '0;
  logic              tempValid = 1'b0;
  logic [1:0]        tempRef = 2'd0;
  logic [RAIL_W-1:0] railVal = '0;
  logic              railValid = 1'b0;
  logic [CNT_W-1:0]  txErrCnt = '0, rxErrCnt = '0;
  logic busOff = 0, errPassive = 0, thermTrip = 0, recovStart = 0, recovEnd = 0, errFrame = 0;
  logic [$clog2(DEPTH)-1:0] rdIdx = '0;

  logic winActive, rdValid;
  logic [$clog2(DEPTH+1)-1:0] recCount;
  logic [OVF_W-1:0] overflowCnt;
  logic [VER_W-1:0] rdVersion;
  logic [1:0] rdTempRef;
  logic [TS_W-1:0] rdStartTs, rdEndTs, rdRecovDur;
  logic [TEMP_W-1:0] rdTempMax, rdTempMean;
  logic [RAIL_W-1:0] rdRailMin;
  logic [CNT_W-1:0] rdTecPeak, rdRecPeak, rdTecDelta, rdRecDelta;
  logic [EVC_W-1:0] rdBusOffCnt, rdErrFrameCnt;

  evt_window_recorder #(
    .TS_W(TS_W), .TEMP_W(TEMP_W), .RAIL_W(RAIL_W), .CNT_W(CNT_W), .EVC_W(EVC_W),
    .VER_W(VER_W), .WIN_VER(WIN_VER), .DEPTH(DEPTH), .OVF_W(OVF_W),
    .MAX_WIN(MAX_WIN), .EP_HOLD(EP_HOLD)
  ) u_dut (.*);

  int checks = 0, failures = 0;
  bit done = 0, noise = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {
    int unsigned startTs, endTs, tMax, tMean, rMin, tecPk, recPk;
    int unsigned tecDl, recDl, boN, efN, dur, ver, tref;
  } rec_t;

  rec_t hist[$];            // newest at index 0
  int unsigned mOvf = 0;
  bit mActive = 0, mBoPrev = 0, mRecSt = 0;
  int mLen = 0, mEpRun = 0;
  int unsigned mStart = 0, mTref = 0, mTmax = 0, mSum = 0, mCnt = 0, mRmin = 0;
  int unsigned mTecOpen = 0, mRecOpen = 0, mTecPk = 0, mRecPk = 0, mBoN = 0, mEfN = 0, mRecTs = 0;

  task automatic mAccum(input bit boEdge);
    if (tempValid) begin
      if (tempVal > mTmax) mTmax = tempVal;
      mSum += tempVal; mCnt++;
    end
    if (railValid && railVal < mRmin) mRmin = railVal;
    if (txErrCnt > mTecPk) mTecPk = txErrCnt;
    if (rxErrCnt > mRecPk) mRecPk = rxErrCnt;
    if (boEdge) mBoN++;
    if (errFrame) mEfN++;
    if (recovStart && !mRecSt) begin mRecSt = 1; mRecTs = tsNow; end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist.delete(); mOvf = 0; mActive = 0; mBoPrev = 0; mEpRun = 0; mLen = 0;
    end else begin
      bit boE, epF;
      rec_t r;
      boE = busOff && !mBoPrev;
      epF = errPassive && (mEpRun == EP_HOLD - 1);
      if (!mActive) begin
        if (boE || epF || thermTrip || recovStart) begin
          mStart = tsNow; mTref = tempRef; mTmax = 0; mSum = 0; mCnt = 0;
          mRmin = (1 << RAIL_W) - 1; mTecOpen = txErrCnt; mRecOpen = rxErrCnt;
          mTecPk = 0; mRecPk = 0; mBoN = 0; mEfN = 0; mRecSt = 0; mRecTs = 0;
          mAccum(boE);
          mActive = 1; mLen = 1;
        end
      end else begin
        mAccum(boE);
        if (recovEnd || mLen == MAX_WIN - 1) begin
          r.startTs = mStart; r.endTs = tsNow; r.tMax = mTmax;
          r.tMean = (mCnt == 0) ? 0 : mSum / mCnt; r.rMin = mRmin;
          r.tecPk = mTecPk; r.recPk = mRecPk;
          r.tecDl = (txErrCnt >= mTecOpen) ? txErrCnt - mTecOpen : 0;
          r.recDl = (rxErrCnt >= mRecOpen) ? rxErrCnt - mRecOpen : 0;
          r.boN = mBoN; r.efN = mEfN; r.dur = mRecSt ? tsNow - mRecTs : 0;
          r.ver = WIN_VER; r.tref = mTref;
          hist.push_front(r);
          if (hist.size() > DEPTH) begin void'(hist.pop_back()); mOvf++; end
          mActive = 0; mLen = 0;
        end else mLen++;
      end
      mBoPrev = busOff;
      if (!errPassive) mEpRun = 0;
      else if (mEpRun < EP_HOLD) mEpRun++;
    end
  end

  // ---------------- per-cycle comparison ----------------
  task automatic compareAll();
    int n = hist.size();
    bit v = (int'(rdIdx) < n);
    chk("R1/R2 winActive", winActive, mActive);
    chk("R10 recCount", recCount, n);
    chk("R11 overflowCnt", overflowCnt, mOvf);
    chk("R10 rdValid", rdValid, v);
    if (v) begin
      rec_t e = hist[rdIdx];
      chk("R3 startTs", rdStartTs, e.startTs);
      chk("R3 endTs", rdEndTs, e.endTs);
      chk("R4 tempMax", rdTempMax, e.tMax);
      chk("R4 tempMean", rdTempMean, e.tMean);
      chk("R5 railMin", rdRailMin, e.rMin);
      chk("R6 tecPeak", rdTecPeak, e.tecPk);
      chk("R6 recPeak", rdRecPeak, e.recPk);
      chk("R6 tecDelta", rdTecDelta, e.tecDl);
      chk("R6 recDelta", rdRecDelta, e.recDl);
      chk("R7 busOffCnt", rdBusOffCnt, e.boN);
      chk("R7 errFrameCnt", rdErrFrameCnt, e.efN);
      chk("R8 recovDur", rdRecovDur, e.dur);
      chk("R9 version", rdVersion, e.ver);
      chk("R9 tempRef", rdTempRef, e.tref);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
    tsNow = tsNow + 3;
    thermTrip = 0; recovStart = 0; recovEnd = 0; errFrame = 0;
    if (noise) begin
      int t;
      tempValid = 1'($urandom_range(0, 1));
      tempVal   = TEMP_W'($urandom_range(0, 4095));
      railValid = 1'($urandom_range(0, 1));
      railVal   = RAIL_W'($urandom_range(200, 4000));
      errFrame  = ($urandom_range(0, 3) == 0);
      t = int'(txErrCnt) + int'($urandom_range(0, 6)) - 3;
      txErrCnt = CNT_W'((t < 0) ? 0 : (t > 255) ? 255 : t);
      t = int'(rxErrCnt) + int'($urandom_range(0, 6)) - 3;
      rxErrCnt = CNT_W'((t < 0) ? 0 : (t > 255) ? 255 : t);
    end else begin
      tempValid = 0; railValid = 0;
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) tick();
    // R12 reset state
    chk("R12 reset winActive", winActive, 0);
    chk("R12 reset recCount", recCount, 0);
    chk("R12 reset overflowCnt", overflowCnt, 0);
    chk("R12 reset rdValid", rdValid, 0);
    rstN = 1;
    noise = 1;
    txErrCnt = 40; rxErrCnt = 60;
    repeat (10) tick();

    // Thermal trip window closed by recovery end (R1, R2)
    tempRef = TREF_CASE; thermTrip = 1; tick();
    repeat (20) tick();
    recovEnd = 1; tick();
    repeat (3) tick();
    rdIdx = 2; tick();
    chk("R10 index past fill not valid", rdValid, 0);
    rdIdx = 0;

    // Bus-off window, second edge inside, recovery starts late, timeout close (R2, R7, R8)
    tempRef = TREF_AMBIENT; busOff = 1; tick();
    repeat (8) tick();
    recovStart = 1; tick();
    repeat (5) tick();
    busOff = 0; tick();
    busOff = 1; tick();
    repeat (MAX_WIN + 6) tick();
    chk("R2 timeout closed window", winActive, 0);
    chk("R7 two bus-off edges", rdBusOffCnt, 2);
    chk("R3 timeout span", rdEndTs - rdStartTs, 3 * (MAX_WIN - 1));
    busOff = 0; tick();

    // Error-passive one cycle short opens nothing (R1)
    errPassive = 1; repeat (EP_HOLD - 1) tick();
    errPassive = 0; tick();
    tick();
    chk("R1 short error-passive ignored", winActive, 0);
    errPassive = 1; tempRef = TREF_JUNCTION;
    repeat (EP_HOLD + 2) tick();
    chk("R1 long error-passive opens", winActive, 1);
    errPassive = 0; repeat (5) tick();
    recovEnd = 1; tick();
    tick();

    // Recovery start opens; trip inside ignored (R1, R8)
    recovStart = 1; tick();
    repeat (3) tick();
    thermTrip = 1; tick();
    repeat (3) tick();
    recovEnd = 1; tick();
    tick();
    chk("R8 recovery from trigger cycle", rdRecovDur, rdEndTs - rdStartTs);

    // Window with no samples (R4, R5, R9)
    noise = 0; tick();
    thermTrip = 1; tick();
    repeat (4) tick();
    recovEnd = 1; tick();
    tick();
    chk("R4 empty mean", rdTempMean, 0);
    chk("R4 empty max", rdTempMax, 0);
    chk("R5 empty rail minimum", rdRailMin, 4095);
    chk("R9 version tag", rdVersion, WIN_VER);

    // Fill past depth (R10, R11)
    noise = 1;
    for (int w = 0; w < 3; w++) begin
      thermTrip = 1; tick();
      repeat (2) tick();
      recovEnd = 1; tick();
      repeat (2) tick();
    end
    chk("R11 overflow count", overflowCnt, 4);
    chk("R10 count saturates", recCount, DEPTH);

    // Trigger on closing cycle ignored, next cycle accepted (R1, R2)
    thermTrip = 1; tick();
    tick();
    thermTrip = 1; recovEnd = 1; tick();
    tick();
    chk("R2 no reopen on closing cycle", winActive, 0);
    thermTrip = 1; tick();
    tick();
    chk("R1 reopen after close", winActive, 1);
    recovEnd = 1; tick();
    tick();

    // Readout sweep, newest to oldest (R10)
    for (int i = 0; i < DEPTH; i++) begin
      rdIdx = i[$clog2(DEPTH)-1:0]; tick();
    end
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule